// File: doc/BRIEF.md
# 64-bit Shift Unit with 32-bit Word Mode

This block is the shift stage of a 64-bit integer datapath. It takes an operation code, a 64-bit operand A and a shift amount B. Two flags pick 32-bit word mode and signed (arithmetic) or unsigned (logical) right shifts. It returns a 64-bit result and a flag that says whether the operation code was one the unit accepts.

The count is seven bits wide, so counts from 64 to 127 are legal and behave as very long shifts. In word mode only the low half of A is shifted, by a six-bit count. The upper half of the result is then filled with zeros, or with copies of bit 31 for an arithmetic right shift. The three rotate-and-mask codes are accepted, so the valid flag goes high for them, but their data is held at zero. The unit holds no state, and its outputs follow its inputs in the same cycle.

Top module: `shift_unit`

## Requirements
- R1: `op_i` is 3 bits wide with this encoding: 0 none, 1 shift left, 2 shift right, 3/4/5 rotate variants, 6/7 unused. `res_ok_o` is 1 for codes 1 to 5 and 0 for codes 0, 6 and 7.
- R2: With `word_i`=0 and code 1, `res_o` = (A << B[6:0]) truncated to 64 bits. A count of 64 or more gives zero.
- R3: With `word_i`=0, code 2 and `signed_i`=0, `res_o` = A >> B[6:0] with zero fill. A count of 64 or more gives zero.
- R4: With `word_i`=0, code 2 and `signed_i`=1, `res_o` is A shifted right arithmetically by B[6:0]. A count of 64 or more gives 64 copies of A[63].
- R5: With `word_i`=1 and code 1, `res_o[31:0]` = (A[31:0] << B[5:0]) truncated to 32 bits and `res_o[63:32]` = 0. When B[5] is set, the whole result is zero.
- R6: With `word_i`=1, code 2 and `signed_i`=0, `res_o[31:0]` = A[31:0] >> B[5:0] and `res_o[63:32]` = 0.
- R7: With `word_i`=1, code 2 and `signed_i`=1, `res_o[31:0]` is A[31:0] shifted right arithmetically by B[5:0], and `res_o[63:32]` holds copies of A[31]. When B[5] is set, the whole result is copies of A[31].
- R8: B[63:7] has no effect on the result in any mode. In word mode, B[6] has no effect either.
- R9: For every code other than 1 and 2, `res_o` is zero.
- R10: `signed_i` has no effect on shift-left results.
- R11: The unit is combinational: a change at the inputs shows at the outputs in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 3 | Operation code (see R1) |
| a_i | input | 64 | Operand to shift |
| b_i | input | 64 | Shift amount; only the low bits are used |
| word_i | input | 1 | 1 selects 32-bit word mode |
| signed_i | input | 1 | 1 selects an arithmetic right shift |
| res_o | output | 64 | Shift result |
| res_ok_o | output | 1 | 1 when the operation code is accepted |

## Verification
The bench builds the unit with the default width of 64. The seven-bit count then reaches every value from 0 to 127, and the half-width shifters see six-bit counts from 0 to 63. This covers the counts that land exactly on the 32- and 64-bit boundaries and those that go past them. Random counts are drawn evenly over that range, so the saturated cases turn up often, next to the directed patterns for sign fill, stray high bits of B and the codes that are not shifts.

// File: rtl/shift_pkg.sv
package shift_pkg;

    localparam int XLEN_DEF = 64;
    localparam int OP_W     = 3;

    typedef enum logic [OP_W-1:0] {
        OPC_NONE  = 3'd0,
        OPC_SHL   = 3'd1,
        OPC_SHR   = 3'd2,
        OPC_ROT   = 3'd3,
        OPC_ROTR  = 3'd4,
        OPC_ROTL  = 3'd5,
        OPC_RSV6  = 3'd6,
        OPC_RSV7  = 3'd7
    } shift_op_e;

    typedef struct packed {
        logic left;
        logic right;
        logic ok;
    } op_class_t;

    function automatic op_class_t classify(shift_op_e op);
        op_class_t c;
        c = '0;
        unique case (op)
            OPC_SHL:                    begin c.left  = 1'b1; c.ok = 1'b1; end
            OPC_SHR:                    begin c.right = 1'b1; c.ok = 1'b1; end
            OPC_ROT, OPC_ROTR, OPC_ROTL: c.ok = 1'b1;
            default:                    c = '0;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/shift_barrel.sv
module shift_barrel #(
    parameter int W    = 64,
    parameter int CW   = 7,
    parameter bit LEFT = 1'b1
) (
    input  logic [W-1:0]  din_i,
    input  logic [CW-1:0] cnt_i,
    input  logic          fill_i,
    output logic [W-1:0]  dout_o
);
    logic [W-1:0] stage [CW+1];

    assign stage[0] = din_i;

    for (genvar i = 0; i < CW; i++) begin : g_stage
        localparam int S = 1 << i;
        logic [W-1:0] moved;
        if (S >= W) begin : g_flood
            assign moved = {W{fill_i}};
        end else if (LEFT) begin : g_left
            assign moved = {stage[i][W-1-S:0], {S{fill_i}}};
        end else begin : g_right
            assign moved = {{S{fill_i}}, stage[i][W-1:S]};
        end
        assign stage[i+1] = cnt_i[i] ? moved : stage[i];
    end

    assign dout_o = stage[CW];
endmodule

// File: rtl/shift_decode.sv
module shift_decode
    import shift_pkg::*;
(
    input  logic [OP_W-1:0] op_i,
    output op_class_t       cls_o
);
    always_comb begin
        cls_o = classify(shift_op_e'(op_i));
    end
endmodule

// File: rtl/shift_merge.sv
module shift_merge
    import shift_pkg::*;
#(
    parameter int XLEN = XLEN_DEF
) (
    input  op_class_t           cls_i,
    input  logic                word_i,
    input  logic                half_fill_i,
    input  logic [XLEN-1:0]     full_l_i,
    input  logic [XLEN-1:0]     full_r_i,
    input  logic [XLEN/2-1:0]   half_l_i,
    input  logic [XLEN/2-1:0]   half_r_i,
    output logic [XLEN-1:0]     data_o
);
    localparam int HALF = XLEN / 2;

    always_comb begin
        data_o = '0;
        if (cls_i.left) begin
            data_o = word_i ? {{HALF{1'b0}}, half_l_i} : full_l_i;
        end else if (cls_i.right) begin
            data_o = word_i ? {{HALF{half_fill_i}}, half_r_i} : full_r_i;
        end
    end
endmodule

// File: rtl/shift_unit.sv
module shift_unit
    import shift_pkg::*;
#(
    parameter int XLEN = XLEN_DEF
) (
    input  logic [OP_W-1:0] op_i,
    input  logic [XLEN-1:0] a_i,
    input  logic [XLEN-1:0] b_i,
    input  logic            word_i,
    input  logic            signed_i,
    output logic [XLEN-1:0] res_o,
    output logic            res_ok_o
);
    localparam int HALF   = XLEN / 2;
    localparam int CNT_W  = $clog2(XLEN) + 1;
    localparam int HCNT_W = $clog2(HALF) + 1;

    op_class_t         cls;
    logic [XLEN-1:0]   full_l, full_r;
    logic [HALF-1:0]   half_l, half_r;
    logic              full_fill, half_fill;
    logic              unused_b;

    assign unused_b  = ^b_i[XLEN-1:CNT_W];
    assign full_fill = signed_i & a_i[XLEN-1];
    assign half_fill = signed_i & a_i[HALF-1];

    shift_decode u_dec (.op_i(op_i), .cls_o(cls));

    shift_barrel #(.W(XLEN), .CW(CNT_W), .LEFT(1'b1)) u_full_l (
        .din_i(a_i), .cnt_i(b_i[CNT_W-1:0]), .fill_i(1'b0), .dout_o(full_l));
    shift_barrel #(.W(XLEN), .CW(CNT_W), .LEFT(1'b0)) u_full_r (
        .din_i(a_i), .cnt_i(b_i[CNT_W-1:0]), .fill_i(full_fill), .dout_o(full_r));
    shift_barrel #(.W(HALF), .CW(HCNT_W), .LEFT(1'b1)) u_half_l (
        .din_i(a_i[HALF-1:0]), .cnt_i(b_i[HCNT_W-1:0]), .fill_i(1'b0), .dout_o(half_l));
    shift_barrel #(.W(HALF), .CW(HCNT_W), .LEFT(1'b0)) u_half_r (
        .din_i(a_i[HALF-1:0]), .cnt_i(b_i[HCNT_W-1:0]), .fill_i(half_fill), .dout_o(half_r));

    shift_merge #(.XLEN(XLEN)) u_merge (
        .cls_i(cls), .word_i(word_i), .half_fill_i(half_fill),
        .full_l_i(full_l), .full_r_i(full_r),
        .half_l_i(half_l), .half_r_i(half_r),
        .data_o(res_o));

    assign res_ok_o = cls.ok;
endmodule

// File: rtl/shift_unit_chk.sv
module shift_unit_chk #(
    parameter int XLEN = 64
) (
    input logic [2:0]      op_i,
    input logic [XLEN-1:0] a_i,
    input logic [XLEN-1:0] b_i,
    input logic            word_i,
    input logic            signed_i,
    input logic [XLEN-1:0] res_o,
    input logic            res_ok_o
);
    localparam int HALF  = XLEN / 2;
    localparam int CNT_W = $clog2(XLEN) + 1;

    logic unused_chk;
    assign unused_chk = ^{a_i, b_i};

    always_comb begin
        // R1: accepted codes are 1..5
        a_r1_ok_decode: assert (res_ok_o == (op_i >= 3'd1 && op_i <= 3'd5))
            else $error("R1 valid flag mismatch");
        // R9: non-shift codes give zero data
        if (op_i != 3'd1 && op_i != 3'd2)
            a_r9_idle_zero: assert (res_o == '0) else $error("R9 data not zero");
        // R5/R6: word left and word logical right clear the upper half
        if (word_i && (op_i == 3'd1 || (op_i == 3'd2 && !signed_i)))
            a_r5_word_upper_zero: assert (res_o[XLEN-1:HALF] == '0)
                else $error("R5 upper half not zero");
        // R7: word arithmetic right fills upper half with bit 31
        if (word_i && op_i == 3'd2 && signed_i)
            a_r7_word_sign_fill: assert (res_o[XLEN-1:HALF] == {HALF{a_i[HALF-1]}})
                else $error("R7 upper half not sign fill");
        // R2: full-width left by 64 or more is zero
        if (!word_i && op_i == 3'd1 && b_i[CNT_W-1])
            a_r2_long_left_zero: assert (res_o == '0) else $error("R2 long left");
        // R4: full-width arithmetic right by 64 or more is all sign
        if (!word_i && op_i == 3'd2 && signed_i && b_i[CNT_W-1])
            a_r4_long_arith_fill: assert (res_o == {XLEN{a_i[XLEN-1]}})
                else $error("R4 long arithmetic right");
    end
endmodule

bind shift_unit shift_unit_chk #(.XLEN(XLEN)) u_chk (.*);

// File: tb/sim_shift_unit.sv
module sim_shift_unit;
    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic [2:0]  op;
    logic [63:0] a, b;
    logic        word, sgn;
    logic [63:0] res;
    logic        res_ok;

    int vectors = 0;
    int errors  = 0;
    bit done    = 1'b0;

    shift_unit u0 (.op_i(op), .a_i(a), .b_i(b), .word_i(word), .signed_i(sgn),
                   .res_o(res), .res_ok_o(res_ok));

    function automatic void model(input logic [2:0] o, input logic [63:0] x,
                                  input logic [63:0] y, input logic w, input logic s,
                                  output logic [63:0] d, output logic ok);
        logic [6:0]         c  = y[6:0];
        logic [5:0]         hc = y[5:0];
        logic [31:0]        lo;
        logic signed [63:0] sx;
        logic signed [31:0] slo;
        d = '0;
        ok = (o >= 3'd1 && o <= 3'd5);
        if (o == 3'd1) begin
            if (w) begin lo = x[31:0] << hc; d = {32'd0, lo}; end
            else d = x << c;
        end else if (o == 3'd2) begin
            if (w) begin
                if (s) begin slo = x[31:0]; slo = slo >>> hc; d = {{32{x[31]}}, slo}; end
                else begin lo = x[31:0] >> hc; d = {32'd0, lo}; end
            end else begin
                if (s) begin sx = x; sx = sx >>> c; d = sx; end
                else d = x >> c;
            end
        end
    endfunction

    function automatic string tag_of(input logic [2:0] o, input logic w, input logic s);
        if (o == 3'd1) return w ? "R5" : "R2";
        if (o == 3'd2) return w ? (s ? "R7" : "R6") : (s ? "R4" : "R3");
        return "R9";
    endfunction

    task automatic apply(input logic [2:0] o, input logic [63:0] x, input logic [63:0] y,
                         input logic w, input logic s, input string tag);
        logic [63:0] ed;
        logic        eok;
        @(posedge clk);
        #1;
        op = o; a = x; b = y; word = w; sgn = s;
        model(o, x, y, w, s, ed, eok);
        @(negedge clk);
        vectors++;
        if (res !== ed || res_ok !== eok) begin
            errors++;
            $display("FAIL %s op=%0d w=%0d s=%0d a=%h b=%h: got %h/%b exp %h/%b",
                     tag, o, w, s, x, y, res, res_ok, ed, eok);
        end
    endtask

    initial begin
        op = 3'd0; a = '0; b = '0; word = 1'b0; sgn = 1'b0;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        // idle state: code 0 gives zero data and no valid (R1, R9)
        apply(3'd0, 64'd0, 64'd0, 1'b0, 1'b0, "R1");
        // R1: every code, valid flag and data
        for (int k = 0; k < 8; k++) apply(3'(k), 64'hF0F0_1234_5678_9ABC, 64'd3, 1'b0, 1'b0, "R1");
        // R9: rotate and unused codes in word mode and signed
        for (int k = 3; k < 8; k++) apply(3'(k), 64'hFFFF_FFFF_FFFF_FFFF, 64'd5, 1'b1, 1'b1, "R9");
        // R2: boundary counts
        apply(3'd1, 64'h8000_0000_0000_0001, 64'd63, 1'b0, 1'b0, "R2");
        apply(3'd1, 64'hFFFF_FFFF_FFFF_FFFF, 64'd64, 1'b0, 1'b0, "R2");
        apply(3'd1, 64'hFFFF_FFFF_FFFF_FFFF, 64'd127, 1'b0, 1'b0, "R2");
        // R3
        apply(3'd2, 64'h8000_0000_0000_0000, 64'd63, 1'b0, 1'b0, "R3");
        apply(3'd2, 64'hFFFF_FFFF_FFFF_FFFF, 64'd64, 1'b0, 1'b0, "R3");
        // R4
        apply(3'd2, 64'h8000_0000_0000_0000, 64'd1, 1'b0, 1'b1, "R4");
        apply(3'd2, 64'h8000_0000_0000_0000, 64'd100, 1'b0, 1'b1, "R4");
        apply(3'd2, 64'h7FFF_FFFF_FFFF_FFFF, 64'd100, 1'b0, 1'b1, "R4");
        // R5
        apply(3'd1, 64'hDEAD_BEEF_0000_0001, 64'd31, 1'b1, 1'b0, "R5");
        apply(3'd1, 64'hDEAD_BEEF_FFFF_FFFF, 64'd32, 1'b1, 1'b0, "R5");
        // R6
        apply(3'd2, 64'hFFFF_FFFF_8000_0000, 64'd31, 1'b1, 1'b0, "R6");
        apply(3'd2, 64'hFFFF_FFFF_FFFF_FFFF, 64'd40, 1'b1, 1'b0, "R6");
        // R7
        apply(3'd2, 64'h0000_0000_8000_0000, 64'd4, 1'b1, 1'b1, "R7");
        apply(3'd2, 64'hFFFF_FFFF_8000_0000, 64'd33, 1'b1, 1'b1, "R7");
        apply(3'd2, 64'hFFFF_FFFF_7FFF_FFFF, 64'd63, 1'b1, 1'b1, "R7");
        // R8: stray high bits of B, and B[6] in word mode
        apply(3'd1, 64'h0123_4567_89AB_CDEF, 64'hFFFF_FFFF_FFFF_FF84, 1'b0, 1'b0, "R8");
        apply(3'd2, 64'h8123_4567_89AB_CDEF, 64'hAAAA_AAAA_AAAA_AA05, 1'b0, 1'b1, "R8");
        apply(3'd1, 64'h0123_4567_89AB_CDEF, 64'h0000_0000_0000_0045, 1'b1, 1'b0, "R8");
        apply(3'd2, 64'h0123_4567_89AB_CDEF, 64'h0000_0000_0000_0044, 1'b1, 1'b1, "R8");
        // R10: signed flag on left shifts
        apply(3'd1, 64'h8000_0000_0000_00FF, 64'd4, 1'b0, 1'b1, "R10");
        apply(3'd1, 64'h0000_0000_8000_00FF, 64'd4, 1'b1, 1'b1, "R10");
        // random sweep over all modes (R11: each result checked in its own cycle)
        for (int k = 0; k < 3000; k++) begin
            logic [2:0]  ro = (k % 4 == 3) ? 3'($urandom_range(0, 7)) : 3'($urandom_range(1, 2));
            logic [63:0] ra = {$urandom, $urandom};
            logic [63:0] rb = {$urandom, $urandom};
            logic        rw = 1'($urandom);
            logic        rs = 1'($urandom);
            if (k % 2 == 0) rb = {57'd0, rb[6:0]};
            apply(ro, ra, rb, rw, rs, (k % 5 == 0) ? "R11" : tag_of(ro, rw, rs));
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end
endmodule